// File: doc/BRIEF.md
# Four-Lane Skew-Absorbing Bit Interleaver

This block merges four single-bit lanes into one serial stream that runs at four times the lane rate. Every lane arrives on the block's fast clock, and each lane has its own write strobe. The strobe of a lane fires once per four fast cycles, at a phase that the block does not know and that may drift. Each lane writes into its own ten-entry elastic store. Once per group of four fast cycles, one bit is pulled from every store together. The four bits are then sent one after another, with lane 0 first.

Reset puts every store at mid-fill. The write side starts five entries ahead of the read side, and those five entries hold zeros. This leaves room for the lanes to arrive several bits early or late against the group timing. If a store runs completely empty or completely full, a sticky flag is raised for that lane only, and the flag clears only on reset. A test input replaces the lane data with a full-rate pseudo-random sequence generated inside the block. This drives a self-test of the link.

Top module: `es_interleave`

## Requirements
- R1: With `test_en` low, `sout` carries one stored bit per clock. `sout_mark` is 1 on the cycle that carries the lane 0 bit of a group. The next three cycles carry the bits of lanes 1, 2 and 3 from the same group.
- R2: Once data flows, `sout_mark` is high on exactly one cycle out of every four.
- R3: Each cycle with `lane_stb[i]` high stores `lane_bit[i]` in lane i. Once per group, one bit is read from every lane. Each lane delivers its bits in the order they were stored.
- R4: Reset centers every store with five zero entries. The first five bits delivered per lane after reset are 0, and the lane's stored bits follow them.
- R5: A store is written and read correctly when its write and read fall on the same cycle. A lane whose strobes come up to three bits late or early against the read timing loses no data and raises no flag.
- R6: `ovf[i]` goes to 1 when lane i's fill level reaches 0 or 10. No other lane's flag changes.
- R7: A set `ovf[i]` stays set until reset.
- R8: While `test_en` is high, `sout` carries the sequence b[n] = b[n-23] XOR b[n-18], one bit per clock, starting from an all-ones state. `sout_mark` is 0 during this time.
- R9: During reset and on the first cycle after it, `sout`, `sout_mark` and all `ovf` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the lane bit rate |
| rst | input | 1 | Synchronous active-high reset; re-centers the stores |
| lane_stb | input | LANES | Per-lane write strobe |
| lane_bit | input | LANES | Per-lane data bit |
| test_en | input | 1 | Selects the internal pseudo-random sequence for the output |
| sout | output | 1 | Interleaved serial output |
| sout_mark | output | 1 | High on the cycle that carries the lane 0 bit |
| ovf | output | LANES | Sticky per-lane fill-limit flags |

## Verification
A lane write and the group read can hit the same store in the same cycle. The bench provokes this by giving the four lanes four distinct strobe phases, so one lane always lines up with the read cycle. It then shifts lanes three bits late and three bits early. A scoreboard queue per lane predicts the stream: five zeros, then every bit that was strobed in. Each output bit is judged by comparing it against the head of that queue, so a collision that dropped or repeated a bit would show up as a mismatch.

// File: rtl/es_pkg.sv
package es_pkg;
  // Pattern generator shape: feedback taps at stage 23 and stage 18
  localparam int PAT_LEN = 23;
  localparam int PAT_TAP = 18;
endpackage

// File: rtl/es_lane.sv
module es_lane #(
  parameter int DEPTH  = 10,
  parameter int CENTER = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit,
  output logic ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] store;
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [OW-1:0]    level, level_nxt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // fill level saturates at the limits; reaching either limit flags the lane
  always_comb begin
    level_nxt = level;
    if (wr_en && !rd_en && level != OW'(DEPTH))
      level_nxt = level + OW'(1);
    else if (rd_en && !wr_en && level != '0)
      level_nxt = level - OW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store  <= '0;
      wr_ptr <= PW'(CENTER);
      rd_ptr <= '0;
      level  <= OW'(CENTER);
      rd_bit <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      if (wr_en) begin
        store[wr_ptr] <= wr_bit;
        wr_ptr        <= bump(wr_ptr);
      end
      if (rd_en) begin
        rd_bit <= store[rd_ptr];
        rd_ptr <= bump(rd_ptr);
      end
      level <= level_nxt;
      if ((wr_en || rd_en) && (level_nxt == '0 || level_nxt == OW'(DEPTH)))
        ovf <= 1'b1;
    end
  end

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r4_centered: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level == OW'(CENTER) && !ovf));
  a_r6_empty_flags: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> ovf);
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int LEN = 23,
  parameter int TAP = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic bit_o
);
  logic [LEN-1:0] state;

  // state[k] holds the bit produced k+1 steps ago
  assign bit_o = state[LEN-1] ^ state[TAP-1];

  always_ff @(posedge clk) begin
    if (rst)       state <= '1;
    else if (step) state <= {state[LEN-2:0], bit_o};
  end

  a_r8_state_live: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/es_interleave.sv
module es_interleave
  import es_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 10,
  parameter int CENTER = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_stb,
  input  logic [LANES-1:0] lane_bit,
  input  logic             test_en,
  output logic             sout,
  output logic             sout_mark,
  output logic [LANES-1:0] ovf
);
  localparam int SW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SW-1:0]    slot;
  logic             rd_tick;
  logic             primed;
  logic [LANES-1:0] rd_bits;
  logic             pat_bit;

  assign rd_tick = (slot == SW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst)          slot <= '0;
    else if (rd_tick) slot <= '0;
    else              slot <= slot + SW'(1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    es_lane #(.DEPTH(DEPTH), .CENTER(CENTER)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (lane_stb[g]),
      .wr_bit (lane_bit[g]),
      .rd_en  (rd_tick),
      .rd_bit (rd_bits[g]),
      .ovf    (ovf[g])
    );
  end

  prbs_gen #(.LEN(PAT_LEN), .TAP(PAT_TAP)) u_pat (
    .clk   (clk),
    .rst   (rst),
    .step  (test_en),
    .bit_o (pat_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      sout      <= 1'b0;
      sout_mark <= 1'b0;
    end else begin
      if (rd_tick) primed <= 1'b1;
      if (test_en) begin
        sout      <= pat_bit;
        sout_mark <= 1'b0;
      end else begin
        sout      <= primed & rd_bits[slot];
        sout_mark <= primed && (slot == '0);
      end
    end
  end

  a_r2_mark_gap: assert property (@(posedge clk) disable iff (rst)
    sout_mark |=> !sout_mark);
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sout && !sout_mark && ovf == '0));
  a_r8_no_mark_in_test: assert property (@(posedge clk) disable iff (rst)
    $past(test_en) |-> !sout_mark);
endmodule

// File: tb/test_es_interleave.sv
module test_es_interleave;
  localparam int LANES  = 4;
  localparam int DEPTH  = 10;
  localparam int CENTER = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LANES-1:0] lane_stb = '0;
  logic [LANES-1:0] lane_bit = '0;
  logic             test_en = 1'b0;
  logic             sout, sout_mark;
  logic [LANES-1:0] ovf;

  es_interleave #(.LANES(LANES), .DEPTH(DEPTH), .CENTER(CENTER)) i_es_interleave (
    .clk(clk), .rst(rst), .lane_stb(lane_stb), .lane_bit(lane_bit),
    .test_en(test_en), .sout(sout), .sout_mark(sout_mark), .ovf(ovf)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit exp_q [LANES][$];
  int phase [LANES], mode [LANES], skip_n [LANES], extra_n [LANES];
  int cyc = 0, mon_idx = -1, since_mark = -1;
  bit cmp_on = 0, done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as bits leave the block
  always @(negedge clk) begin : mon
    bit e;
    if (rst) begin
      mon_idx    = -1;
      since_mark = -1;
    end else if (cmp_on && !test_en) begin
      if (since_mark >= 0) since_mark++;
      if (sout_mark) begin
        if (since_mark >= 0) check(since_mark == 4, "R2 mark spacing", since_mark, 4);
        since_mark = 0;
        mon_idx    = 0;
      end
      if (mon_idx >= 0) begin
        if (exp_q[mon_idx].size() == 0) begin
          check(0, "R3 output with empty lane queue", sout, 0);
        end else begin
          e = exp_q[mon_idx].pop_front();
          check(sout == e, $sformatf("R1 R3 R4 lane %0d bit", mon_idx), sout, e);
        end
        mon_idx = (mon_idx == LANES - 1) ? -1 : mon_idx + 1;
      end
    end
  end

  // driver: strobes lanes and pushes what it writes
  task automatic step_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
        bit s;
        s = 0;
        if (mode[i] == 2) s = 1;
        else if (mode[i] == 1) begin
          if (cyc % LANES == phase[i]) begin
            if (skip_n[i] > 0) skip_n[i]--;
            else s = 1;
          end else if (extra_n[i] > 0 && cyc % LANES == (phase[i] + 2) % LANES) begin
            extra_n[i]--;
            s = 1;
          end
        end
        lane_stb[i] = s;
        lane_bit[i] = 1'($urandom_range(0, 1));
        if (s) exp_q[i].push_back(lane_bit[i]);
      end
      cyc++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lane_stb = '0; test_en = 0; cmp_on = 0;
    repeat (3) @(negedge clk);
    check(ovf == '0 && !sout && !sout_mark, "R9 outputs in reset", {ovf, sout, sout_mark}, 0);
    for (int i = 0; i < LANES; i++) begin
      exp_q[i].delete();
      repeat (CENTER) exp_q[i].push_back(1'b0);
    end
    cyc = 0;
    rst = 0;
  endtask

  initial begin : main
    bit pb [300];
    int ones;
    for (int i = 0; i < LANES; i++) begin
      phase[i] = i; mode[i] = 1; skip_n[i] = 0; extra_n[i] = 0;
    end
    repeat (4) @(negedge clk);
    check(!sout && !sout_mark && ovf == '0, "R9 initial reset state", {ovf, sout, sout_mark}, 0);

    // normal flow, one lane always colliding with the read cycle
    do_reset();
    cmp_on = 1;
    step_cycles(160);
    check(ovf == '0, "R5 steady flow flags", ovf, 0);
    skip_n[3] = 3;              // lane 3 drifts three bits late
    step_cycles(80);
    extra_n[0] = 3;             // lane 0 drifts three bits early
    step_cycles(80);
    check(ovf == '0, "R5 drift of three bits", ovf, 0);

    // different phase assignment
    for (int i = 0; i < LANES; i++) phase[i] = (i + 1) % LANES;
    do_reset();
    cmp_on = 1;
    step_cycles(120);
    check(ovf == '0, "R5 shifted phases", ovf, 0);

    // self-test pattern
    do_reset();
    test_en = 1;
    ones = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      pb[k] = sout;
      ones += int'(sout);
      if (sout_mark) check(0, "R8 mark during test", 1, 0);
    end
    for (int k = 25; k < 300; k++)
      check(pb[k] == (pb[k-23] ^ pb[k-18]), $sformatf("R8 recurrence at %0d", k), pb[k], pb[k-23] ^ pb[k-18]);
    check(ones > 0, "R8 pattern not all zero", ones, 1);
    test_en = 0;

    // overflow: lane 1 floods, lane 2 starves
    for (int i = 0; i < LANES; i++) phase[i] = i;
    do_reset();
    mode[1] = 2; mode[2] = 0;
    step_cycles(80);
    check(ovf == 4'b0110, "R6 per-lane limit flags", ovf, 4'b0110);
    mode[1] = 1; mode[2] = 1;
    step_cycles(80);
    check(ovf == 4'b0110, "R7 flags stay set", ovf, 4'b0110);

    // reset re-centers
    do_reset();
    @(negedge clk);
    check(ovf == '0, "R4 flags cleared by reset", ovf, 0);
    for (int i = 0; i < LANES; i++) exp_q[i].delete();
    // one cycle already run without driver: rebuild expectation from reset
    do_reset();
    cmp_on = 1;
    step_cycles(120);
    check(ovf == '0, "R4 recentered flow", ovf, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule